// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This sequencer drives the memory side of a multi-register load or store. A single start pulse delivers a base address, a 16-bit register mask, a two-bit addressing mode, a writeback enable, a load/store select, a privileged-transfer bit and the address of the current instruction. From these inputs the block works out how many words move and where the first one sits. It then issues one word request per accepted cycle, each carrying an address and a register index. The requests go out over a valid/ready pair, and the memory handshake can stall them for any number of cycles.

When the last word has been accepted, the block raises a single-cycle completion strobe. Alongside that strobe it presents the new base value, whether that value is to be written back, the address of the next instruction, whether that address came from memory, and whether the status word must be restored from its saved copy. Register file contents and memory data stay outside the block. The only exception is the word returned for register 15, which the block captures as the redirect target.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start with N bits set in the register mask produces exactly N accepted requests before `done` rises.
- R2: The first request address depends on the mode. Mode 0 (increment-after) uses base. Mode 1 (increment-before) uses base+4. Mode 2 (decrement-after) uses base−4N+4. Mode 3 (decrement-before) uses base−4N.
- R3: Requests carry register indices in strictly ascending order, one for each set mask bit, and each accepted request is followed by one whose address is 4 higher.
- R4: While `req_valid` is high and `req_ready` is low, the request address and register index hold steady and no transfer is counted.
- R5: An empty mask issues no request, and `done` rises in the cycle right after the start edge.
- R6: `done` rises one cycle after the last accepted request and lasts exactly one cycle. With it, `wb_addr` is base+4N for modes 0 and 1 and base−4N for modes 2 and 3. `wb_valid` equals `done` ANDed with the writeback enable given at start.
- R7: `status_restore` pulses with `done` only for a load that has the privileged bit set and mask bit 15 set.
- R8: `req_user_bank` is high on every request exactly when the privileged bit is set and mask bit 15 is clear.
- R9: At `done`, `next_pc` holds the `mem_rdata` value seen when register 15 was accepted for a load that includes bit 15, and `pc_redirect` is high. In every other case `next_pc` is `pc_in`+4 and `pc_redirect` is low.
- R10: A start pulse that arrives while a transfer is in progress is ignored. The running sequence continues unchanged and produces no additional requests.
- R11: `req_write` is high on every request of a store and low on every request of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| base_addr | input | 32 | Base register value |
| reg_mask | input | 16 | Registers to transfer, bit i = register i |
| amode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_en | input | 1 | Write final address back to base |
| is_load | input | 1 | 1 load, 0 store |
| priv_bit | input | 1 | Status-restore / user-bank qualifier |
| pc_in | input | 32 | Address of the current instruction |
| req_valid | output | 1 | Word request pending |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | 32 | Word address |
| req_reg | output | 4 | Register index of this word |
| req_write | output | 1 | Store direction |
| req_user_bank | output | 1 | Use user-mode register bank |
| mem_rdata | input | 32 | Load data, sampled on handshake of register 15 |
| done | output | 1 | One-cycle completion strobe |
| wb_valid | output | 1 | Writeback requested (with done) |
| wb_addr | output | 32 | Final base value |
| next_pc | output | 32 | Next instruction address (with done) |
| pc_redirect | output | 1 | next_pc came from memory |
| status_restore | output | 1 | Restore status from saved copy |

## Verification
The bench uses the default 32-bit address and 16-entry mask. It sweeps every single-bit mask, the empty mask, the full mask and several mixed masks. Each mask is run in all four addressing modes, in both directions, and with the privileged bit both clear and set. A pseudo-random ready pattern adds stalls throughout. Because of this sweep, the extreme start offsets (down to base−64), the bit-15 cases for redirect, restore and user bank, and a mid-transfer start are all exercised. At every cycle the bench checks each request against addresses and indices it derives from the mask.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] reg_mask,
  input  logic [1:0]    amode,
  input  logic          wb_en,
  input  logic          is_load,
  input  logic          priv_bit,
  input  logic [AW-1:0] pc_in,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [$clog2(LW)-1:0] req_reg,
  output logic          req_write,
  output logic          req_user_bank,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [AW-1:0] next_pc,
  output logic          pc_redirect,
  output logic          status_restore
);
  localparam int IW = $clog2(LW);
  localparam int CW = $clog2(LW + 1);

  logic          busy;
  logic [LW-1:0] pend;
  logic [AW-1:0] addr_q, wb_q, pc_q;
  logic          ld_q, priv_q, top_q, wben_q;

  logic [CW-1:0] cnt;
  logic [IW-1:0] low_idx;
  logic [AW-1:0] span, first_addr;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LW; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = LW - 1; i >= 0; i--) if (pend[i]) low_idx = IW'(i);
  end

  assign span = AW'(STEP) * AW'(cnt);

  always_comb begin
    case (amode)
      2'd0:    first_addr = base_addr;
      2'd1:    first_addr = base_addr + AW'(STEP);
      2'd2:    first_addr = base_addr - span + AW'(STEP);
      default: first_addr = base_addr - span;
    endcase
  end

  wire accept = start && !busy;
  wire hs     = busy && req_ready;
  wire last   = hs && ((pend & (pend - LW'(1))) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      addr_q <= '0;
      wb_q   <= '0;
      pc_q   <= '0;
      ld_q   <= 1'b0;
      priv_q <= 1'b0;
      top_q  <= 1'b0;
      wben_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= (accept && reg_mask == '0) || last;
      if (accept) begin
        busy   <= reg_mask != '0;
        pend   <= reg_mask;
        addr_q <= first_addr;
        wb_q   <= amode[1] ? base_addr - span : base_addr + span;
        pc_q   <= pc_in + AW'(STEP);
        ld_q   <= is_load;
        priv_q <= priv_bit;
        top_q  <= reg_mask[LW-1];
        wben_q <= wb_en;
      end else if (hs) begin
        pend[low_idx] <= 1'b0;
        addr_q        <= addr_q + AW'(STEP);
        if (last) busy <= 1'b0;
        if (ld_q && low_idx == IW'(LW - 1)) pc_q <= mem_rdata;
      end
    end
  end

  assign req_valid      = busy;
  assign req_addr       = addr_q;
  assign req_reg        = low_idx;
  assign req_write      = !ld_q;
  assign req_user_bank  = priv_q && !top_q;
  assign wb_valid       = done && wben_q;
  assign wb_addr        = wb_q;
  assign next_pc        = pc_q;
  assign pc_redirect    = done && ld_q && top_q;
  assign status_restore = done && ld_q && priv_q && top_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last) |=> (req_valid && req_addr == $past(req_addr) + AW'(STEP))); // R3
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last) |=> (req_reg > $past(req_reg))); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg))); // R4
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_valid && reg_mask == '0) |=> (done && !req_valid)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (pend & (pend - LW'(1))) == '0) |=> (done && !req_valid)); // R6
  AST_RESTORE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore |-> (done && pc_redirect)); // R7
endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  amode = '0;
  logic        wb_en = 1'b0, is_load = 1'b0, priv_bit = 1'b0;
  logic [31:0] pc_in = '0;
  logic        req_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_valid, req_write, req_user_bank, done, wb_valid, pc_redirect, status_restore;
  logic [31:0] req_addr, wb_addr, next_pc;
  logic [3:0]  req_reg;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_NS/2) clk = ~clk;

  blk_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .reg_mask(reg_mask),
    .amode(amode), .wb_en(wb_en), .is_load(is_load), .priv_bit(priv_bit), .pc_in(pc_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_reg(req_reg),
    .req_write(req_write), .req_user_bank(req_user_bank), .mem_rdata(mem_rdata),
    .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr), .next_pc(next_pc),
    .pc_redirect(pc_redirect), .status_restore(status_restore));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kth_reg(input logic [15:0] m, input int k);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin
      if (c == k) return i;
      c++;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return a ^ 32'h5A3C_0000;
  endfunction

  task automatic run(input logic [15:0] m, input logic [1:0] md, input bit ld, input bit pv,
                     input bit wb, input logic [31:0] base, input logic [31:0] pc, input bit stray);
    int n = 0;
    int k = 0;
    int cyc = 0;
    logic [31:0] exp_a, exp_wb, exp_pc;
    bit pend_done = 1'b0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    case (md)
      2'd0: exp_a = base;
      2'd1: exp_a = base + 4;
      2'd2: exp_a = base - 32'(4*n) + 4;
      default: exp_a = base - 32'(4*n);
    endcase
    exp_wb = md[1] ? base - 32'(4*n) : base + 32'(4*n);
    exp_pc = pc + 4;
    @(negedge clk);
    reg_mask = m; amode = md; is_load = ld; priv_bit = pv; wb_en = wb;
    base_addr = base; pc_in = pc; start = 1'b1; req_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) chk(done === 1'b1 && req_valid === 1'b0, "R5 empty done", {31'd0, done}, 32'd1);
    while (cyc < 200) begin
      if (done) begin
        chk(k == n, "R1 count", 32'(k), 32'(n));
        chk(wb_addr === exp_wb, "R6 wb_addr", wb_addr, exp_wb);
        chk(wb_valid === wb, "R6 wb_valid", {31'd0, wb_valid}, {31'd0, wb});
        chk(status_restore === (ld && pv && m[15]), "R7 restore", {31'd0, status_restore}, {31'd0, ld && pv && m[15]});
        chk(pc_redirect === (ld && m[15]), "R9 redirect", {31'd0, pc_redirect}, {31'd0, ld && m[15]});
        chk(next_pc === exp_pc, "R9 next_pc", next_pc, exp_pc);
        break;
      end
      if (pend_done) begin
        chk(1'b0, "R6 done late", 32'd0, 32'd1);
        break;
      end
      chk(req_valid === 1'b1, "R1 req_valid", {31'd0, req_valid}, 32'd1);
      chk(req_addr === exp_a, "R2 R3 address", req_addr, exp_a);
      chk(int'(req_reg) == kth_reg(m, k), "R3 reg order", 32'(req_reg), 32'(kth_reg(m, k)));
      chk(req_write === !ld, "R11 direction", {31'd0, req_write}, {31'd0, !ld});
      chk(req_user_bank === (pv && !m[15]), "R8 user bank", {31'd0, req_user_bank}, {31'd0, pv && !m[15]});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = lfsr[0] | lfsr[1];
      start = stray && (cyc == 1);
      if (start) base_addr = base + 32'h100;
      mem_rdata = mem_of(req_addr);
      if (req_ready) begin
        if (ld && req_reg == 4'd15) exp_pc = mem_of(req_addr);
        k++;
        exp_a += 4;
        if (k == n) pend_done = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      req_ready = 1'b0;
      cyc++;
    end
    if (cyc >= 200) chk(1'b0, "R1 no done", 32'(cyc), 32'd0);
    @(negedge clk);
    chk(done === 1'b0 && req_valid === 1'b0, "R6 R10 quiet after done", {30'd0, done, req_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] masks [22];
    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h8001; masks[3] = 16'h5A3C;
    masks[4] = 16'h8000; masks[5] = 16'h00F0;
    for (int i = 0; i < 16; i++) masks[6 + i] = 16'(1) << i;
    repeat (2) @(negedge clk);
    chk(req_valid === 1'b0 && done === 1'b0, "R1 reset state", {30'd0, req_valid, done}, 32'd0);
    rst_n = 1'b1;
    for (int mi = 0; mi < 22; mi++)
      for (int md = 0; md < 4; md++)
        for (int ld = 0; ld < 2; ld++)
          for (int pv = 0; pv < 2; pv++)
            run(masks[mi], 2'(md), ld[0], pv[0], (mi + md) % 2 == 0,
                32'h0000_1000 + 32'(mi * 64), 32'h0000_8000 + 32'(md * 16), 1'b0);
    run(16'hFFFF, 2'd3, 1'b1, 1'b0, 1'b1, 32'h0000_0040, 32'h100, 1'b1); // R10 stray start mid-run
    run(16'h5A3C, 2'd0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFF0, 32'h200, 1'b1); // R10 with address wrap
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule